// File: doc/BRIEF.md
# DMA Shadow Region Interrupt Controller

This block keeps the completion-pending and interrupt-enable state for 32 transfer-completion codes of a DMA engine. It presents that state to several hosts through per-region shadow windows. Each region has a 32-bit access mask that serves two purposes. It limits which channel bits the region can see and change through its window, and it picks which completion codes may raise that region's interrupt line. Masks of different regions may overlap. One completion can therefore interrupt several regions at once.

Software configures the masks through a global register window. Each host then uses its own shadow window to enable, inspect and clear its channels. Each region also has an evaluate register that its access mask does not gate. Writing it re-fires the region interrupt while enabled pending work remains, so an edge that a host missed can be recovered.

Each region runs a two-state machine. RG_QUIET means the region's combined condition is false. RG_HELD means it is true. The QUIET to HELD transition, taken when the condition becomes true, emits a one-cycle interrupt pulse. The HELD to QUIET transition is taken when the condition clears. HELD to HELD is taken while the condition stays true, and it pulses only on an evaluate write. QUIET to QUIET is taken while the condition stays false. The combined condition is the OR over all bits of (pending AND enable AND region mask).

Top module: `shadow_irq_ctrl`

## Requirements
- R1: The access mask of region n (n < NR, default NR = 4) is written and read back at byte address 0x340 + 8*n, for every implemented region.
- R2: Mask slots at 0x340 + 8*n with NR <= n <= 7 read as 0 and ignore writes.
- R3: Register offsets within a window are 0x00 enable (read), 0x04 enable-set, 0x08 enable-clear, 0x0C pending (read), 0x10 pending-clear and 0x14 evaluate. The global window is at 0x1000 and is unmasked. The shadow window of region n is at 0x2000 + 0x200*n. Through a shadow window, reads return the value ANDed with that region's mask, and set and clear writes act only on bits set in the mask.
- R4: A cycle with cmpl_valid high sets pending bit cmpl_code.
- R5: irq[n] is high for exactly one cycle, one clock after the region's combined condition goes from false to true. It does not pulse again while the condition stays true.
- R6: When two regions' masks share a bit, a completion on that code pulses both irq lines in the same cycle.
- R7: Writing 1 to bit 0 at shadow offset 0x14 of region n pulses irq[n] one clock later if the condition is true at that write, and does nothing otherwise. A write of 0 does nothing.
- R8: Enable-set, enable-clear and pending-clear are write-1-to-act. Bits written as 0 are unchanged.
- R9: A completion and a pending-clear of the same bit in the same cycle leave the bit set.
- R10: Reset clears all pending bits, enable bits and masks, and holds irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_code | input | 5 | Completion code of the finished transfer |
| irq | output | NR | One interrupt pulse line per region |

## Verification
A wrong pending, enable or mask bit shows at the ports within one clock. A read through the affected window returns it, and the irq pulse one clock after a completion appears on the wrong region or is missing. A region machine stuck in RG_HELD shows as a missing pulse on the next rising condition. A machine stuck in RG_QUIET shows as repeated pulses on later completions for codes that are already pending. A wrong priority between clear and completion leaves a pending bit cleared, and the next read of the global pending register shows it.

// File: rtl/shadow_irq_pkg.sv
package shadow_irq_pkg;
    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 32;
    localparam int CODE_W      = $clog2(DATA_W);
    localparam int SLOT_W      = 3;
    localparam int MAX_REGIONS = 1 << SLOT_W;
    localparam int OFF_W       = 9;

    localparam logic [9:0] MASK_PAGE = 10'h00D;   // 0x340..0x37F
    localparam logic [6:0] GLOB_PAGE = 7'h08;     // 0x1000..0x11FF
    localparam logic [3:0] SHAD_PAGE = 4'h2;      // 0x2000..0x2FFF

    localparam logic [OFF_W-1:0] OFF_EN       = 9'h000;
    localparam logic [OFF_W-1:0] OFF_EN_SET   = 9'h004;
    localparam logic [OFF_W-1:0] OFF_EN_CLR   = 9'h008;
    localparam logic [OFF_W-1:0] OFF_PEND     = 9'h00C;
    localparam logic [OFF_W-1:0] OFF_PEND_CLR = 9'h010;
    localparam logic [OFF_W-1:0] OFF_EVAL     = 9'h014;

    typedef enum logic {
        RG_QUIET = 1'b0,
        RG_HELD  = 1'b1
    } rg_state_t;
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
    import shadow_irq_pkg::*;
#(
    parameter int NR = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic                      cmpl_valid,
    input  logic [CODE_W-1:0]         cmpl_code,
    output logic [DATA_W-1:0]         pend_q,
    output logic [DATA_W-1:0]         en_q,
    output logic [NR-1:0][DATA_W-1:0] mask_q,
    output logic [NR-1:0]             eval_hit
);
    logic              sel_mask, sel_glob, sel_shad;
    logic [SLOT_W-1:0] slot;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] vmask, en_set, en_clr, pend_clr, pend_set;

    // Address decode and the view mask of the addressed window
    always_comb begin
        sel_mask = (bus_addr[15:6] == MASK_PAGE) && (bus_addr[2:0] == 3'd0);
        sel_glob = (bus_addr[15:9] == GLOB_PAGE);
        sel_shad = (bus_addr[15:12] == SHAD_PAGE);
        off      = bus_addr[8:0];
        slot     = sel_mask ? bus_addr[5:3] : bus_addr[11:9];
        vmask    = sel_glob ? '1 : '0;
        for (int r = 0; r < NR; r++) begin
            if (sel_shad && slot == SLOT_W'(r)) vmask = mask_q[r];
        end
        en_set   = (bus_wr && off == OFF_EN_SET)   ? (bus_wdata & vmask) : '0;
        en_clr   = (bus_wr && off == OFF_EN_CLR)   ? (bus_wdata & vmask) : '0;
        pend_clr = (bus_wr && off == OFF_PEND_CLR) ? (bus_wdata & vmask) : '0;
        pend_set = cmpl_valid ? (DATA_W'(1) << cmpl_code) : '0;
        for (int r = 0; r < NR; r++) begin
            eval_hit[r] = bus_wr && sel_shad && slot == SLOT_W'(r)
                          && off == OFF_EVAL && bus_wdata[0];
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (sel_mask) begin
            for (int r = 0; r < NR; r++) begin
                if (slot == SLOT_W'(r)) bus_rdata = mask_q[r];
            end
        end else begin
            case (off)
                OFF_EN:   bus_rdata = en_q & vmask;
                OFF_PEND: bus_rdata = pend_q & vmask;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // State: completion wins over clear; enable clear wins over set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~pend_clr) | pend_set;
            en_q   <= (en_q | en_set) & ~en_clr;
            for (int r = 0; r < NR; r++) begin
                if (bus_wr && sel_mask && slot == SLOT_W'(r)) mask_q[r] <= bus_wdata;
            end
        end
    end
endmodule

// File: rtl/sirq_region_fsm.sv
module sirq_region_fsm
    import shadow_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic eval_hit,
    output logic irq
);
    rg_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RG_QUIET: state_d = cond ? RG_HELD : RG_QUIET;
            RG_HELD:  state_d = cond ? RG_HELD : RG_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RG_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= cond && (state_q == RG_QUIET || eval_hit);
    end
endmodule

// File: rtl/shadow_irq_ctrl.sv
module shadow_irq_ctrl
    import shadow_irq_pkg::*;
#(
    parameter int NR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmpl_valid,
    input  logic [CODE_W-1:0] cmpl_code,
    output logic [NR-1:0]     irq
);
    logic [DATA_W-1:0]         pend_q, en_q;
    logic [NR-1:0][DATA_W-1:0] mask_q;
    logic [NR-1:0]             eval_hit;
    logic [NR-1:0]             cond;

    sirq_regs #(.NR(NR)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code),
        .pend_q(pend_q), .en_q(en_q), .mask_q(mask_q), .eval_hit(eval_hit)
    );

    for (genvar r = 0; r < NR; r++) begin : g_region
        assign cond[r] = |(pend_q & en_q & mask_q[r]);
        sirq_region_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .cond(cond[r]),
            .eval_hit(eval_hit[r]), .irq(irq[r])
        );
    end
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker
    import shadow_irq_pkg::*;
#(
    parameter int NR = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      cmpl_valid,
    input logic [CODE_W-1:0]         cmpl_code,
    input logic [NR-1:0]             irq,
    input logic [DATA_W-1:0]         pend_q,
    input logic [NR-1:0]             cond,
    input logic [NR-1:0][DATA_W-1:0] mask_q,
    input logic [NR-1:0]             eval_hit
);
    AST_CMPL_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> pend_q[$past(cmpl_code)]); // R4

    AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[15:6] == MASK_PAGE && bus_addr[2:0] == 3'd0
         && int'(bus_addr[5:3]) >= NR) |-> bus_rdata == '0); // R2

    for (genvar r = 0; r < NR; r++) begin : g_chk
        AST_IRQ_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
            irq[r] |-> $past(cond[r])); // R5

        AST_REPEAT_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[r] && $past(irq[r])) |-> $past(eval_hit[r])); // R7

        AST_SHADOW_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr[15:9] == {SHAD_PAGE, SLOT_W'(r)}) |-> (bus_rdata & ~mask_q[r]) == '0); // R3
    end
endmodule

bind shadow_irq_ctrl sirq_checker #(.NR(NR)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code), .irq(irq),
    .pend_q(pend_q), .cond(cond), .mask_q(mask_q), .eval_hit(eval_hit)
);

// File: tb/shadow_irq_ctrl_bench.sv
module shadow_irq_ctrl_bench;
    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmpl_valid = 1'b0;
    logic [4:0]  cmpl_code = '0;
    logic [NR-1:0] irq;
    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    shadow_irq_ctrl #(.NR(NR)) u_shadow_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmpl_valid(cmpl_valid),
        .cmpl_code(cmpl_code), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk); bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic cmpl(input logic [4:0] c);
        @(negedge clk); cmpl_valid = 1'b1; cmpl_code = c;
        @(negedge clk); cmpl_valid = 1'b0;
    endtask

    // irq now, then low one cycle later
    task automatic irq_pulse(input string req, input logic [NR-1:0] exp);
        check(req, 32'(irq), 32'(exp));
        @(negedge clk);
        check(req, 32'(irq), 32'h0);
    endtask

    task automatic t_reset;
        check("R10 irq", 32'(irq), 32'h0);
        for (int r = 0; r < NR; r++) rd_chk("R10 mask", 16'(16'h340 + 8*r), 32'h0);
        rd_chk("R10 enable", 16'h1000, 32'h0);
        rd_chk("R10 pending", 16'h100C, 32'h0);
    endtask

    task automatic t_masks;
        for (int r = 0; r < NR; r++) wr(16'(16'h340 + 8*r), 32'hA5A5_0000 | 32'(r));
        for (int r = 0; r < NR; r++) rd_chk("R1 mask readback", 16'(16'h340 + 8*r), 32'hA5A5_0000 | 32'(r));
        wr(16'h0368, 32'hFFFF_FFFF);
        wr(16'h0378, 32'hFFFF_FFFF);
        rd_chk("R2 slot5", 16'h0368, 32'h0);
        rd_chk("R2 slot7", 16'h0378, 32'h0);
        wr(16'h0340, 32'h0000_00FF);
        wr(16'h0348, 32'h0000_0F01);
        wr(16'h0350, 32'h0000_0000);
        wr(16'h0358, 32'hFFFF_0000);
        rd_chk("R1 region1 mask", 16'h0348, 32'h0000_0F01);
    endtask

    task automatic t_shadow_view;
        wr(16'h2004, 32'hFFFF_FFFF);
        rd_chk("R3 shadow set masked", 16'h1000, 32'h0000_00FF);
        rd_chk("R3 shadow read masked", 16'h2200, 32'h0000_0001);
        wr(16'h1008, 32'hFFFF_FFFF);
        rd_chk("R8 enable clear", 16'h1000, 32'h0);
        wr(16'h2604, 32'h0001_0001);
        rd_chk("R3 region3 set", 16'h1000, 32'h0001_0000);
        rd_chk("R3 empty mask read", 16'h2400, 32'h0);
        check("R5 no irq without pending", 32'(irq), 32'h0);
    endtask

    task automatic t_completion;
        cmpl(5'd16);
        @(negedge clk);
        irq_pulse("R5 region3 pulse", 4'b1000);
        rd_chk("R4 pending bit16", 16'h100C, 32'h0001_0000);
        cmpl(5'd16);
        @(negedge clk);
        check("R5 no refire while held", 32'(irq), 32'h0);
        @(negedge clk);
        check("R5 no refire while held", 32'(irq), 32'h0);
    endtask

    task automatic t_overlap;
        wr(16'h1004, 32'h0000_0001);
        check("R8 set alone no irq", 32'(irq), 32'h0);
        cmpl(5'd0);
        @(negedge clk);
        irq_pulse("R6 overlap both regions", 4'b0011);
    endtask

    task automatic t_eval;
        wr(16'h2014, 32'h1);
        irq_pulse("R7 eval region0", 4'b0001);
        wr(16'h2414, 32'h1);
        irq_pulse("R7 eval no condition", 4'b0000);
        wr(16'h2614, 32'h0);
        irq_pulse("R7 eval write zero", 4'b0000);
        wr(16'h2614, 32'h1);
        irq_pulse("R7 eval region3", 4'b1000);
    endtask

    task automatic t_shadow_clear;
        wr(16'h2210, 32'hFFFF_FFFF);
        rd_chk("R3 shadow clear masked", 16'h100C, 32'h0001_0000);
        wr(16'h2010, 32'h0001_0000);
        rd_chk("R3 clear outside mask ignored", 16'h100C, 32'h0001_0000);
    endtask

    task automatic t_collision;
        @(negedge clk);
        cmpl_valid = 1'b1; cmpl_code = 5'd5;
        bus_wr = 1'b1; bus_addr = 16'h1010; bus_wdata = 32'h0000_0020;
        @(negedge clk);
        cmpl_valid = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd_chk("R9 completion beats clear", 16'h100C, 32'h0001_0020);
        wr(16'h1010, 32'h0000_0020);
        rd_chk("R8 pending clear", 16'h100C, 32'h0001_0000);
        cmpl(5'd31);
        rd_chk("R4 pending bit31", 16'h100C, 32'h8001_0000);
        check("R5 disabled code no irq", 32'(irq), 32'h0);
    endtask

    task automatic t_enable_clear;
        wr(16'h1008, 32'h0001_0000);
        wr(16'h2614, 32'h1);
        irq_pulse("R7 eval after enable clear", 4'b0000);
        rd_chk("R8 enable after clear", 16'h1000, 32'h0000_0001);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_shadow_view();
        t_completion();
        t_overlap();
        t_eval();
        t_shadow_clear();
        t_collision();
        t_enable_clear();
        finish_run();
    end
endmodule